// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synchronous single-port memory. Its address, control and byte-enable inputs are all registered. A command is sampled on a rising clock edge. The data that belongs to that command uses the data bus during the second clock period after that edge, for both reads and writes.

Write data trails its address by the same two periods as read data. Because of this, reads and writes can follow each other in any order at one access per cycle, with no idle cycle when the bus changes direction. A load/advance input chooses between two actions on each cycle:
- load a fresh address and command, or
- step through a four-beat burst that uses the command captured at load, in either linear or interleaved order.

Three chip enables qualify every load. A clock enable freezes the whole pipeline. The bidirectional data bus is modelled as a data-in port, a data-out port and an output-enable flag. The memory is sized small for simulation.

Top module: `zbtSram`

## Requirements
- R1: When a read command is sampled at edge k, `dataOe` is high and `dataOut` holds the stored word during the period between enabled edges k+1 and k+2. Counting uses enabled edges only.
- R2: When a write command is sampled at edge k, the word is taken from `dataIn` at enabled edge k+2. Only lanes enabled by `laneWe` (sampled with the command) are stored.
- R3: Reads and writes may be issued on consecutive cycles in any order with no idle cycle. If a read directly follows a write to the same address, it returns the newly written lanes merged with the stored lanes that were not written.
- R4: An edge with `clkEn` low is ignored. No pipeline stage, burst state, output or memory word changes on that edge.
- R5: A load (`advLoad`=0) starts an access only if `ceAN`=0, `ceB`=1 and `ceCN`=0. Otherwise the cycle is a deselect, and `dataOe` stays low in its data period.
- R6: When `burstLinear`=1 at load, advance cycles (`advLoad`=1) access low address bits (start+n) mod 4, where n=1,2,3,0,… The upper bits stay fixed.
- R7: When `burstLinear`=0 at load, advance cycles access low bits start XOR n, where n counts the beats. The upper bits stay fixed.
- R8: On a write, lane i is bits [9i+8:9i] and is stored only when `laneWe[i]`=1. Lanes with `laneWe[i]`=0 keep their old value.
- R9: An advance cycle reuses the read/write command and the chip-select result of the last load. It ignores `writeSel` and the chip enables. After a deselect load, advances perform no access.
- R10: `dataOe` is low during the data period of a write or a deselect, and in every cycle where no read data is due.
- R11: While `rstN` is low at an edge, the pipeline empties, `dataOe` goes low, and the burst state becomes a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| clkEn | input | 1 | Clock enable, high to accept the edge |
| ceAN | input | 1 | Chip enable, active low |
| ceB | input | 1 | Chip enable, active high |
| ceCN | input | 1 | Chip enable, active low |
| advLoad | input | 1 | 0 = load new command, 1 = advance burst |
| writeSel | input | 1 | 1 = write, 0 = read (used on load) |
| burstLinear | input | 1 | 1 = linear order, 0 = interleaved (used on load) |
| addr | input | ADDR_W | Word address (used on load) |
| laneWe | input | LANES | Per-lane write enables, sampled with the command |
| dataIn | input | LANES*BYTE_W | Write data, sampled two enabled edges after its command |
| dataOut | output | LANES*BYTE_W | Read data |
| dataOe | output | 1 | High while `dataOut` carries read data |

## Verification
Four properties are checked on every cycle:
- a frozen edge leaves the outputs unchanged;
- every captured read raises the output enable one edge later;
- every non-read edge lowers it;
- the enable never rises without a captured read.

Other behaviours can only be shown by the bench's scenarios, which compare each cycle against a behavioural model. These are the address order of the linear and interleaved bursts, the lane merge, forwarding from a write still in flight, and the effect of the chip-enable decode on data two cycles later.

// File: rtl/zbtSramPkg.sv
package zbtSramPkg;
  // Strobes from the sequencer to the storage/datapath side.
  typedef struct packed {
    logic advance;    // this edge is enabled
    logic rdCapture;  // a read reaches its capture point on this edge
    logic wrCommit;   // a write reaches its commit point on this edge
  } pipeStrobe_t;
endpackage

// File: rtl/zbtSramCtrl.sv
module zbtSramCtrl
  import zbtSramPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LANES     = 4,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              ceAN,
  input  logic              ceB,
  input  logic              ceCN,
  input  logic              advLoad,
  input  logic              writeSel,
  input  logic              burstLinear,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  laneWe,
  output pipeStrobe_t       strb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LANES-1:0]  wrLanes
);
  localparam int BEAT_W = $clog2(BURST_LEN);

  // Burst state captured at load
  logic              burstSel, burstWr, burstLin;
  logic [ADDR_W-1:0] burstBase;
  logic [BEAT_W-1:0] beat;

  // Two command stages between sampling and data
  logic              stgValid [2];
  logic              stgWr    [2];
  logic [ADDR_W-1:0] stgAddr  [2];
  logic [LANES-1:0]  stgLanes [2];

  logic              chipSel;
  logic [BEAT_W-1:0] nextBeat, lowStart, advLow;
  logic              curValid, curWr;
  logic [ADDR_W-1:0] curAddr;

  assign chipSel  = !ceAN && ceB && !ceCN;
  assign nextBeat = beat + BEAT_W'(1);
  assign lowStart = burstBase[BEAT_W-1:0];
  assign advLow   = burstLin ? (lowStart + nextBeat) : (lowStart ^ nextBeat);

  always_comb begin
    if (!advLoad) begin
      curValid = chipSel;
      curWr    = writeSel;
      curAddr  = addr;
    end else begin
      curValid = burstSel;
      curWr    = burstWr;
      curAddr  = {burstBase[ADDR_W-1:BEAT_W], advLow};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstSel  <= 1'b0;
      burstWr   <= 1'b0;
      burstLin  <= 1'b0;
      burstBase <= '0;
      beat      <= '0;
      for (int s = 0; s < 2; s++) begin
        stgValid[s] <= 1'b0;
        stgWr[s]    <= 1'b0;
        stgAddr[s]  <= '0;
        stgLanes[s] <= '0;
      end
    end else if (clkEn) begin
      if (!advLoad) begin
        burstSel  <= chipSel;
        burstWr   <= writeSel;
        burstLin  <= burstLinear;
        burstBase <= addr;
        beat      <= '0;
      end else begin
        beat <= nextBeat;
      end
      stgValid[0] <= curValid;
      stgWr[0]    <= curWr;
      stgAddr[0]  <= curAddr;
      stgLanes[0] <= laneWe;
      stgValid[1] <= stgValid[0];
      stgWr[1]    <= stgWr[0];
      stgAddr[1]  <= stgAddr[0];
      stgLanes[1] <= stgLanes[0];
    end
  end

  assign strb.advance   = clkEn;
  assign strb.rdCapture = clkEn && stgValid[0] && !stgWr[0];
  assign strb.wrCommit  = clkEn && stgValid[1] && stgWr[1];
  assign rdAddr  = stgAddr[0];
  assign wrAddr  = stgAddr[1];
  assign wrLanes = stgLanes[1];
endmodule

// File: rtl/zbtSramDatapath.sv
module zbtSramDatapath
  import zbtSramPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pipeStrobe_t             strb,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [LANES-1:0]        wrLanes,
  input  logic [LANES*BYTE_W-1:0] dataIn,
  output logic [LANES*BYTE_W-1:0] dataOut,
  output logic                    dataOe
);
  localparam int DATA_W = LANES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdWord;
  logic              sameWord;

  assign sameWord = strb.wrCommit && (wrAddr == rdAddr);

  // Lane-wise forward of the word committing on this very edge
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign rdWord[g*BYTE_W +: BYTE_W] = (sameWord && wrLanes[g])
      ? dataIn[g*BYTE_W +: BYTE_W] : mem[rdAddr][g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (strb.wrCommit) begin
      for (int l = 0; l < LANES; l++) begin
        if (wrLanes[l]) mem[wrAddr][l*BYTE_W +: BYTE_W] <= dataIn[l*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOe  <= 1'b0;
      dataOut <= '0;
    end else if (strb.advance) begin
      dataOe <= strb.rdCapture;
      if (strb.rdCapture) dataOut <= rdWord;
    end
  end
endmodule

// File: rtl/zbtSram.sv
module zbtSram
  import zbtSramPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEn,
  input  logic                    ceAN,
  input  logic                    ceB,
  input  logic                    ceCN,
  input  logic                    advLoad,
  input  logic                    writeSel,
  input  logic                    burstLinear,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        laneWe,
  input  logic [LANES*BYTE_W-1:0] dataIn,
  output logic [LANES*BYTE_W-1:0] dataOut,
  output logic                    dataOe
);
  localparam int DATA_W = LANES * BYTE_W;

  pipeStrobe_t       pipeStrb;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [LANES-1:0]  wrLanes;

  zbtSramCtrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_LEN(4)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .ceAN(ceAN), .ceB(ceB), .ceCN(ceCN),
    .advLoad(advLoad), .writeSel(writeSel), .burstLinear(burstLinear),
    .addr(addr), .laneWe(laneWe), .strb(pipeStrb),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .wrLanes(wrLanes)
  );

  zbtSramDatapath #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(pipeStrb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .wrLanes(wrLanes), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/zbtSramChecker.sv
module zbtSramChecker
  import zbtSramPkg::*;
#(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              dataOe,
  input logic [DATA_W-1:0] dataOut,
  input pipeStrobe_t       strb
);
  // R4: an ignored edge leaves the output register untouched
  assert_freeze_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(dataOe) && $stable(dataOut)));

  // R1: a captured read drives the bus in the following period
  assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdCapture |=> dataOe);

  // R10: an enabled edge without a read capture releases the bus
  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.rdCapture) |=> !dataOe);

  // R1: output enable never rises without a read behind it
  assert_oe_has_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> $past(strb.rdCapture));
endmodule

bind zbtSram zbtSramChecker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .dataOe(dataOe),
  .dataOut(dataOut), .strb(pipeStrb)
);

// File: tb/sim_zbtSram.sv
`timescale 1ns/1ps
module sim_zbtSram;
  localparam int AW = 8;
  localparam int LN = 4;
  localparam int BW = 9;
  localparam int DW = LN * BW;

  logic clk = 1'b0;
  logic rstN, clkEn, ceAN, ceB, ceCN, advLoad, writeSel, burstLinear;
  logic [AW-1:0] addr;
  logic [LN-1:0] laneWe;
  logic [DW-1:0] dataIn, dataOut;
  logic dataOe;

  always #4 clk = ~clk;

  zbtSram #(.ADDR_W(AW), .LANES(LN), .BYTE_W(BW)) u0 (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .ceAN(ceAN), .ceB(ceB), .ceCN(ceCN),
    .advLoad(advLoad), .writeSel(writeSel), .burstLinear(burstLinear),
    .addr(addr), .laneWe(laneWe), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  string tag = "R11";

  // Behavioural reference
  logic [DW-1:0] refMem [1 << AW];
  bit p1v, p1w, p2v, p2w;
  int p1a, p2a;
  logic [LN-1:0] p1l, p2l;
  bit bSel, bWr, bLin;
  int bBase, bBeat;
  bit expOe = 0;
  logic [DW-1:0] expD;

  task automatic modelEdge();
    bit cv, cw;
    int ca;
    if (!rstN) begin
      p1v = 0; p2v = 0; expOe = 0; bSel = 0;
      return;
    end
    if (!clkEn) return;
    if (!advLoad) begin
      cv = (ceAN == 1'b0) && (ceB == 1'b1) && (ceCN == 1'b0);
      cw = writeSel; ca = int'(addr);
      bSel = cv; bWr = writeSel; bLin = burstLinear; bBase = ca; bBeat = 0;
    end else begin
      bBeat = (bBeat + 1) % 4;
      cv = bSel; cw = bWr;
      ca = (bBase / 4) * 4 + (bLin ? ((bBase % 4 + bBeat) % 4) : ((bBase % 4) ^ bBeat));
    end
    if (p2v && p2w)
      for (int l = 0; l < LN; l++)
        if (p2l[l]) refMem[p2a][l*BW +: BW] = dataIn[l*BW +: BW];
    if (p1v && !p1w) begin expOe = 1; expD = refMem[p1a]; end
    else expOe = 0;
    p2v = p1v; p2w = p1w; p2a = p1a; p2l = p1l;
    p1v = cv;  p1w = cw;  p1a = ca;  p1l = laneWe;
  endtask

  task automatic compare();
    checks++;
    if (dataOe !== expOe || (expOe && dataOut !== expD)) begin
      failures++;
      $display("FAIL %s cycle %0d: oe=%b data=%h expected oe=%b data=%h",
               tag, cyc, dataOe, dataOut, expOe, expD);
    end
  endtask

  // One clock: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(input bit en, input bit ld, input logic [2:0] ce,
                      input bit wr, input int a, input logic [3:0] ln);
    clkEn = en; advLoad = ld; {ceAN, ceB, ceCN} = ce;
    writeSel = wr; addr = AW'(a); laneWe = ln;
    dataIn = {4'(cyc), 8'(cyc * 7), 24'(cyc * 40503 + 11)};
    @(posedge clk); #1;
    modelEdge();
    @(negedge clk);
    cyc++;
    compare();
  endtask

  localparam logic [2:0] SEL = 3'b010;   // ceAN=0, ceB=1, ceCN=0

  task automatic wrL(input int a, input logic [3:0] ln); step(1, 0, SEL, 1, a, ln); endtask
  task automatic rdL(input int a); step(1, 0, SEL, 0, a, 4'h0); endtask
  task automatic adv(); step(1, 1, SEL, 0, 0, 4'hf); endtask
  task automatic idle(); step(1, 0, 3'b110, 0, 0, 4'h0); endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; burstLinear = 1;
    @(negedge clk);
    // R11: reset state
    tag = "R11";
    repeat (3) step(1, 0, SEL, 0, 0, 4'h0);
    rstN = 1;
    adv(); adv();                       // advances straight after reset: no access
    // R2: back-to-back writes of full words, addresses 0..23
    tag = "R2";
    for (int i = 0; i < 24; i++) wrL(i, 4'hf);
    idle(); idle();
    // R1: back-to-back reads
    tag = "R1";
    for (int i = 0; i < 8; i++) rdL(i);
    idle(); idle();
    // R3: mixed order with no gaps, forwarding from in-flight writes
    tag = "R3";
    wrL(3, 4'hf); rdL(3); wrL(4, 4'hf); rdL(4); rdL(3); wrL(3, 4'h3); rdL(3);
    wrL(5, 4'hf); wrL(6, 4'hf); rdL(5); rdL(6); idle(); idle();
    // R8: lane masking
    tag = "R8";
    wrL(8, 4'b0101); wrL(9, 4'b1000); wrL(10, 4'h0); rdL(8); rdL(9); rdL(10);
    idle(); idle();
    // R4: clock enable freezes everything
    tag = "R4";
    wrL(11, 4'hf); rdL(2);
    step(0, 0, SEL, 1, 2, 4'hf); step(0, 1, SEL, 1, 7, 4'hf);
    rdL(11); step(0, 0, SEL, 0, 1, 4'h0); wrL(12, 4'h6);
    step(0, 0, SEL, 0, 0, 4'h0); rdL(12); idle(); idle();
    // R5: each chip enable inactive alone is a deselect
    tag = "R5";
    step(1, 0, 3'b110, 0, 1, 4'h0);
    step(1, 0, 3'b000, 0, 1, 4'h0);
    step(1, 0, 3'b011, 0, 1, 4'h0);
    step(1, 0, 3'b110, 1, 1, 4'hf);
    rdL(1); idle(); idle(); idle();
    // R6: linear burst read from low bits 2
    tag = "R6";
    burstLinear = 1;
    rdL(18); adv(); adv(); adv(); adv(); idle(); idle();
    // R7: interleaved burst read from low bits 1, then interleaved write burst
    tag = "R7";
    burstLinear = 0;
    rdL(17); adv(); adv(); adv(); idle();
    wrL(23, 4'hf); adv(); adv(); adv();
    burstLinear = 1;
    rdL(20); adv(); adv(); adv(); idle(); idle();
    // R9: advance reuses the loaded command; a deselect load makes advances idle
    tag = "R9";
    step(1, 0, 3'b110, 0, 4, 4'h0); step(1, 1, SEL, 1, 0, 4'hf); step(1, 1, SEL, 0, 0, 4'hf);
    rdL(12); step(1, 1, 3'b110, 1, 0, 4'hf); step(1, 1, SEL, 1, 0, 4'h0);
    idle(); idle();
    // R10: write data periods and deselects leave the bus released
    tag = "R10";
    wrL(30, 4'hf); idle(); wrL(31, 4'hf); rdL(30); wrL(30, 4'hc); rdL(31); idle(); idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule